// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two N x N signed integer matrices on a square grid of multiply-accumulate cells. Each cell talks only to the cells directly beside it. One operand stream enters along the left edge and moves right by one cell per clock. The other stream enters along the top edge and moves down by one cell per clock. Each cell keeps its own product element in a local accumulator for the whole run. When accumulation ends, the results move down the columns and leave the bottom edge one row per clock.

A one-cycle `start` pulse in the idle state does three things: it captures both operand matrices from flat input buses, clears every accumulator and begins the compute phase. The block delays row r of A by r cycles and column c of B by c cycles, so matching operands meet in cell (r,c). Outside their real slots both streams carry zeros, which leave the sums unchanged. The compute phase takes 3N-2 cycles and the drain phase takes N. A one-cycle `done` pulse follows the last output row.

Top module: `systolic_matmul`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `out_valid` and `done` are low.
- R2: A `start` pulse seen while idle captures both matrices and raises `busy` in the next cycle. Element (r,k) of a matrix occupies bits [(r*N+k)*W +: W] of its bus, read as two's complement.
- R3: The result is C = A*B with C(r,c) = sum over k of A(r,k)*B(k,c), computed exactly for any signed operands.
- R4: Accumulators are 2W+log2(N) bits wide, so N products of the most negative operand, and mixed extremes, sum without overflow.
- R5: `out_valid` rises exactly 3N-2 cycles after `busy` rises and stays high for exactly N consecutive cycles. In drain cycle d (counting from 0) `out_row` carries row N-1-d of C, and element c sits in bits [c*AW +: AW] as a signed value.
- R6: `done` is a single-cycle pulse in the cycle right after the last drain cycle, and `busy` is low in that cycle.
- R7: A `start` pulse while `busy` is high is ignored, and so are changes to the operand buses after capture. The timing and results of the current run stay the same.
- R8: A new run may start in the cycle that `done` is high. Its results start from cleared accumulators and contain nothing from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication; honoured only when idle |
| a_mat | input | N*N*W | Left operand matrix A, row-major |
| b_mat | input | N*N*W | Right operand matrix B, row-major |
| busy | output | 1 | A run (compute or drain) is in progress |
| out_valid | output | 1 | `out_row` holds a result row |
| out_row | output | N*AW | One row of C, bottom row first |
| done | output | 1 | One-cycle pulse after the final row |

## Verification
The bound checker watches the control sequence on every cycle. It checks that `busy` only rises after an accepted start, that the first valid row arrives 3N-2 busy cycles into a run, that exactly N valid rows come before `done`, that `done` is a lone pulse with `busy` low, and that no row is valid outside a run. Only the bench scenarios can show that the numbers are right. These cover identity, pseudo-random, all-minimum and mixed-extreme operands, a start pulse and bus change in the middle of a run, and a back-to-back restart. The reference model compares every output on every cycle.

// File: rtl/systolic_matmul.sv
module systolic_matmul #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int AW = 2*W + $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N*W-1:0]  a_mat,
  input  logic [N*N*W-1:0]  b_mat,
  output logic              busy,
  output logic              out_valid,
  output logic [N*AW-1:0]   out_row,
  output logic              done
);

  localparam int TC = 3*N - 2;
  localparam int CW = $clog2(4*N);

  typedef enum logic [1:0] {S_IDLE, S_COMP, S_DRAIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          go;

  logic signed [W-1:0] a_lat [N][N];
  logic signed [W-1:0] b_lat [N][N];
  logic signed [W-1:0] a_inj [N];
  logic signed [W-1:0] b_inj [N];

  assign go        = start && (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign out_valid = (st == S_DRAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_COMP;
          cnt <= '0;
        end
        S_COMP: if (cnt == CW'(TC-1)) begin
          st  <= S_DRAIN;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_DRAIN: if (cnt == CW'(N-1)) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      for (int r = 0; r < N; r++) begin
        for (int k = 0; k < N; k++) begin
          a_lat[r][k] <= a_mat[(r*N+k)*W +: W];
          b_lat[r][k] <= b_mat[(r*N+k)*W +: W];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      a_inj[i] = '0;
      b_inj[i] = '0;
      for (int k = 0; k < N; k++) begin
        if (st == S_COMP && int'(cnt) == i + k) begin
          a_inj[i] = a_lat[i][k];
          b_inj[i] = b_lat[k][i];
        end
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [W-1:0]    a_q, b_q, a_in, b_in;
      logic signed [2*W-1:0]  prod;
      logic signed [AW-1:0]   acc_q, acc_up;

      if (c == 0) begin : g_left
        assign a_in = a_inj[r];
      end else begin : g_inner_a
        assign a_in = g_row[r].g_col[c-1].a_q;
      end

      if (r == 0) begin : g_top
        assign b_in   = b_inj[c];
        assign acc_up = '0;
      end else begin : g_inner_b
        assign b_in   = g_row[r-1].g_col[c].b_q;
        assign acc_up = g_row[r-1].g_col[c].acc_q;
      end

      assign prod = a_in * b_in;

      always_ff @(posedge clk) begin
        if (!rst_n || go) begin
          a_q   <= '0;
          b_q   <= '0;
          acc_q <= '0;
        end else if (st == S_COMP) begin
          a_q   <= a_in;
          b_q   <= b_in;
          acc_q <= acc_q + AW'(prod);
        end else if (st == S_DRAIN) begin
          acc_q <= acc_up;
        end
      end
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_out
    assign out_row[c*AW +: AW] = g_row[N-1].g_col[c].acc_q;
  end

endmodule

// File: rtl/systolic_matmul_chk.sv
module systolic_matmul_chk #(
  parameter int N = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic out_valid,
  input logic done
);

  localparam int LW = $clog2(4*N) + 2;

  logic [LW-1:0] run_len;
  logic [LW-1:0] row_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      run_len <= '0;
      row_cnt <= '0;
    end else begin
      run_len <= run_len + 1'b1;
      row_cnt <= row_cnt + LW'(out_valid);
    end
  end

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_first_row_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (run_len == LW'(3*N-2)));

  assert_row_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (row_cnt == LW'(N)));

  assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == LW'(4*N-2)));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(out_valid));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_valid_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_valid) |=> busy);

endmodule

bind systolic_matmul systolic_matmul_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .out_valid(out_valid), .done(done)
);

// File: tb/tb_systolic_matmul.sv
`timescale 1ns/1ps
module tb_systolic_matmul;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 2*W + $clog2(N);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, start;
  logic [N*N*W-1:0] a_mat, b_mat;
  logic             busy, out_valid, done;
  logic [N*AW-1:0]  out_row;

  systolic_matmul #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat), .b_mat(b_mat),
    .busy(busy), .out_valid(out_valid), .out_row(out_row), .done(done));

  int checks = 0, errors = 0, cycles = 0;
  int ma [N][N];
  int mb [N][N];
  string scen = "R1";

  bit m_busy = 0, m_done = 0;
  int m_t = 0;
  int ec [N][N];

  task automatic pack();
    for (int r = 0; r < N; r++)
      for (int k = 0; k < N; k++) begin
        a_mat[(r*N+k)*W +: W] = W'(ma[r][k]);
        b_mat[(r*N+k)*W +: W] = W'(mb[r][k]);
      end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_t = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_t = 0;
          for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
              ec[r][c] = 0;
              for (int k = 0; k < N; k++) ec[r][c] += ma[r][k] * mb[k][c];
            end
        end
      end else begin
        m_t++;
        if (m_t == 4*N-2) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at cycle %0d", req, scen, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit ev;
      ev = m_busy && (m_t >= 3*N-2);
      chk(busy == m_busy, "R2 busy", int'(busy), int'(m_busy));
      chk(out_valid == ev, "R5 out_valid", int'(out_valid), int'(ev));
      chk(done == m_done, "R6 done", int'(done), int'(m_done));
      if (ev && out_valid) begin
        int row;
        row = N-1 - (m_t - (3*N-2));
        for (int c = 0; c < N; c++)
          chk($signed(out_row[c*AW +: AW]) == ec[row][c], "R3 data",
              int'($signed(out_row[c*AW +: AW])), ec[row][c]);
      end
    end
  end

  task automatic run_job();
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; a_mat = '0; b_mat = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 reset", int'({busy, out_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 after reset", int'({busy, out_valid, done}), 0);

    scen = "R3 identity";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = (r == c) ? 1 : 0;
        mb[r][c] = r*N + c - 7;
      end
    run_job();

    scen = "R3 random";
    for (int n = 0; n < 3; n++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          ma[r][c] = int'($urandom_range(0, 255)) - 128;
          mb[r][c] = int'($urandom_range(0, 255)) - 128;
        end
      run_job();
    end

    scen = "R4 all minimum";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin ma[r][c] = -128; mb[r][c] = -128; end
    run_job();

    scen = "R4 mixed extremes";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin ma[r][c] = 127; mb[r][c] = -128; end
    run_job();

    scen = "R7 start while busy";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin ma[r][c] = r - c; mb[r][c] = r + 2*c; end
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin ma[r][c] = 99; mb[r][c] = -99; end
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);

    scen = "R8 back-to-back";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin ma[r][c] = 1; mb[r][c] = c + 1; end
    run_job();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin ma[r][c] = -3; mb[r][c] = 5 - r; end
    run_job();

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule